// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, through two independent paths. Each path has one storage register. The A-to-B register takes its data from bus A, and the B-to-A register takes its data from bus B. A separate capture strobe controls each register. A register loads whenever its strobe rises, and the enables and selects have no effect on loading. For each direction, a select input picks what the driven bus carries: either the live value of the opposite bus or the value held in that direction's register.

The bus pins are split into separate input, output and output-enable vectors, so the block stays synthesizable. Whatever surrounds the block resolves these vectors into real wired buses. The design is synchronous to one system clock. Each capture strobe passes through a small edge-tracking state machine with three states:

- ARM, entered on reset.
- LOW, entered from ARM or HIGH when the strobe is sampled at 0.
- HIGH, entered from ARM or LOW when the strobe is sampled at 1.

The transition from LOW to HIGH is the only one that loads the register. A strobe that is already high when reset ends therefore goes from ARM to HIGH and captures nothing.

When both directions are enabled in live mode, each bus output copies the opposite bus. With no other driver present, the two buses hold their last value.

Top module: `xcv_reg_transceiver`

## Requirements
- R1: After the asynchronous active-low reset, both stored registers read as 0x00.
- R2: The A-to-B register loads `a_in` on the clock edge where `cp_ab` is sampled at 1 after having been sampled at 0 on the previous edge. It keeps its value while the strobe stays high, on a falling strobe, and while the strobe stays low.
- R3: The B-to-A register loads `b_in` under the same rule, using `cp_ba`.
- R4: Loading happens for every combination of `en_ab`, `en_ba_n`, `sel_ab` and `sel_ba`.
- R5: The data outputs follow the selects. With `sel_ab`=0, `b_out` equals `a_in`; with `sel_ab`=1, `b_out` equals the stored A-to-B value. With `sel_ba`=0, `a_out` equals `b_in`; with `sel_ba`=1, `a_out` equals the stored B-to-A value.
- R6: `b_oe` is all ones when `en_ab`=1 and all zeros when `en_ab`=0.
- R7: `a_oe` is all ones when `en_ba_n`=0 and all zeros when `en_ba_n`=1.
- R8: A strobe that is already high on the first clock edge after reset is not treated as a rising edge. The first load requires a sample at 0 followed by a sample at 1.
- R9: When both strobes rise on the same edge, each register loads the value its own bus carries on that edge.
- R10: With `en_ab`=1, `en_ba_n`=0 and both selects at 0, `b_out` equals `a_in` and `a_out` equals `b_in`. Resolved as wired buses with all external drivers released, both buses keep their last value across clock edges.
- R11: When the live and stored values are equal, toggling a select leaves the output unchanged.
- R12: With `en_ab`=0 and `en_ba_n`=1, both output enables are all zeros, and both registers still load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_ab | input | 1 | Capture strobe for the A-to-B register |
| cp_ba | input | 1 | Capture strobe for the B-to-A register |
| en_ab | input | 1 | Drive bus B, active high |
| en_ba_n | input | 1 | Drive bus A, active low |
| sel_ab | input | 1 | B-side source: 0 = live A, 1 = stored A |
| sel_ba | input | 1 | A-side source: 0 = live B, 1 = stored B |
| a_in | input | 8 | Value present on bus A |
| b_in | input | 8 | Value present on bus B |
| a_out | output | 8 | Data driven toward bus A |
| a_oe | output | 8 | Per-lane drive enable for bus A |
| b_out | output | 8 | Data driven toward bus B |
| b_oe | output | 8 | Per-lane drive enable for bus B |

## Verification
The hardest case to reach from the ports is the self-holding loop. It only shows up once the bench closes the path from outputs back to inputs, the way a wired bus would. The bench first drives bus A, then releases it. After that it repeatedly feeds each enabled output back into its input and confirms that both buses keep their value over several clock edges. A second awkward case is a strobe that is already high when reset ends. The bench holds `cp_ab` high through reset and confirms that no load happens until the strobe has been seen low.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
    typedef enum logic [1:0] {
        EDG_ARM  = 2'd0,
        EDG_LOW  = 2'd1,
        EDG_HIGH = 2'd2
    } edg_state_t;
endpackage

// File: rtl/xcv_edge_fsm.sv
// Tracks one capture strobe and pulses fire on a LOW->HIGH transition.
module xcv_edge_fsm
    import xcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fire
);
    edg_state_t state_q;
    edg_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_ARM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            EDG_ARM: begin
                // first sample after reset only establishes the level
                state_d = strobe ? EDG_HIGH : EDG_LOW;
            end
            EDG_LOW: begin
                if (strobe) begin
                    state_d = EDG_HIGH;
                    fire    = 1'b1;
                end
            end
            EDG_HIGH: begin
                if (!strobe) state_d = EDG_LOW;
            end
            default: state_d = EDG_ARM;
        endcase
    end
endmodule

// File: rtl/xcv_dir_path.sv
// One transfer direction: storage register, hazard-free source mux, drive enable.
module xcv_dir_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src,
    input  logic         sel_stored,
    input  logic         drive,
    output logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= src;
    end

    assign stored = hold_q;

    for (genvar i = 0; i < W; i++) begin : g_lane
        // consensus term keeps the lane steady when both sources agree
        assign dout[i] = (src[i] & ~sel_stored)
                       | (hold_q[i] & sel_stored)
                       | (src[i] & hold_q[i]);
        assign oe[i]   = drive;
    end
endmodule

// File: rtl/xcv_reg_transceiver.sv
module xcv_reg_transceiver #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cp_ab,
    input  logic         cp_ba,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic         fire_ab;
    logic         fire_ba;
    logic [W-1:0] st_ab;
    logic [W-1:0] st_ba;

    xcv_edge_fsm u_edge_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cp_ab),
        .fire   (fire_ab)
    );

    xcv_edge_fsm u_edge_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cp_ba),
        .fire   (fire_ba)
    );

    xcv_dir_path #(.W(W)) u_path_ab (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fire_ab),
        .src        (a_in),
        .sel_stored (sel_ab),
        .drive      (en_ab),
        .stored     (st_ab),
        .dout       (b_out),
        .oe         (b_oe)
    );

    xcv_dir_path #(.W(W)) u_path_ba (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fire_ba),
        .src        (b_in),
        .sel_stored (sel_ba),
        .drive      (~en_ba_n),
        .stored     (st_ba),
        .dout       (a_out),
        .oe         (a_oe)
    );
endmodule

// File: rtl/xcv_checker.sv
module xcv_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cp_ab,
    input logic         cp_ba,
    input logic         en_ab,
    input logic         en_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] st_ab,
    input logic [W-1:0] st_ba
);
    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    AST_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(cp_ab)) |=> (st_ab == $past(a_in)));                 // R2
    AST_AB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$rose(cp_ab)) |=> $stable(st_ab));                        // R2
    AST_BA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(cp_ba)) |=> (st_ba == $past(b_in)));                 // R3
    AST_BA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$rose(cp_ba)) |=> $stable(st_ba));                        // R3
    AST_B_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ab |-> (b_out == a_in));                                       // R5
    AST_A_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ba |-> (a_out == st_ba));                                       // R5
    AST_B_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        en_ab |-> (&b_oe));                                                 // R6
    AST_A_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ba_n |-> (&a_oe));                                              // R7
    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_ab && en_ba_n) |-> ((a_oe == '0) && (b_oe == '0)));            // R12
    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ab && !en_ba_n && !sel_ab && !sel_ba)
            |-> ((b_out == a_in) && (a_out == b_in)));                      // R10
endmodule

bind xcv_reg_transceiver xcv_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cp_ab   (cp_ab),
    .cp_ba   (cp_ba),
    .en_ab   (en_ab),
    .en_ba_n (en_ba_n),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .st_ab   (st_ab),
    .st_ba   (st_ba)
);

// File: tb/sim_xcv_reg_transceiver.sv
`timescale 1ns/1ps
module sim_xcv_reg_transceiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cp_ab = 1'b0, cp_ba = 1'b0;
    logic       en_ab = 1'b0, en_ba_n = 1'b1;
    logic       sel_ab = 1'b0, sel_ba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, a_oe, b_out, b_oe;

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] exp_sa = '0, exp_sb = '0;

    always #2.5 clk = ~clk;

    xcv_reg_transceiver #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cp_ab(cp_ab), .cp_ba(cp_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_ab(input logic [7:0] d);
        cp_ab = 1'b0; tick();
        a_in = d; cp_ab = 1'b1; tick();
        cp_ab = 1'b0; tick();
        exp_sa = d;
    endtask

    task automatic pulse_ba(input logic [7:0] d);
        cp_ba = 1'b0; tick();
        b_in = d; cp_ba = 1'b1; tick();
        cp_ba = 1'b0; tick();
        exp_sb = d;
    endtask

    // read both stored values through the stored-select outputs
    task automatic peek_stored(input string req);
        logic sa, sb;
        sa = sel_ab; sb = sel_ba;
        sel_ab = 1'b1; sel_ba = 1'b1; #0.5;
        check(req, b_out, exp_sa);
        check(req, a_out, exp_sb);
        sel_ab = sa; sel_ba = sb; #0.5;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: strobe held high through reset
        cp_ab = 1'b1; a_in = 8'hC3;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: stored values cleared
        peek_stored("R1");
        repeat (3) tick();
        peek_stored("R8");
        // R2: first real edge loads
        pulse_ab(8'h5A);
        peek_stored("R2");
        cp_ab = 1'b1; tick();
        exp_sa = a_in;
        repeat (3) begin a_in = a_in + 8'h11; tick(); end
        cp_ab = 1'b0; a_in = 8'h00; tick(); tick();
        peek_stored("R2");
        // R3
        pulse_ba(8'hA7);
        b_in = 8'h3E; tick(); tick();
        peek_stored("R3");

        // R4 / R12: loading under every control combination
        for (int c = 0; c < 16; c++) begin
            en_ab = c[0]; en_ba_n = c[1]; sel_ab = c[2]; sel_ba = c[3];
            pulse_ab(8'(c * 17 + 3));
            pulse_ba(8'(c * 29 + 7));
            sel_ab = 1'b0; sel_ba = 1'b0;
            if (c == 2) peek_stored("R12");
            else        peek_stored("R4");
        end

        // R9: simultaneous strobes
        cp_ab = 1'b0; cp_ba = 1'b0; tick();
        a_in = 8'h11; b_in = 8'h22; cp_ab = 1'b1; cp_ba = 1'b1; tick();
        cp_ab = 1'b0; cp_ba = 1'b0; a_in = 8'h99; b_in = 8'h88; tick();
        exp_sa = 8'h11; exp_sb = 8'h22;
        peek_stored("R9");

        // R5 R6 R7 R12: output sweep
        pulse_ab(8'h6C); pulse_ba(8'hD1);
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 4; k++) begin
                en_ab = c[0]; en_ba_n = c[1]; sel_ab = c[2]; sel_ba = c[3];
                a_in = 8'(k * 73 + c * 5 + 1);
                b_in = 8'(k * 41 + c * 11 + 9);
                tick();
                check("R5", b_out, sel_ab ? exp_sa : a_in);
                check("R5", a_out, sel_ba ? exp_sb : b_in);
                check(en_ab ? "R6" : (en_ba_n ? "R12" : "R6"), b_oe, en_ab ? 8'hFF : 8'h00);
                check(en_ba_n ? (en_ab ? "R7" : "R12") : "R7", a_oe, en_ba_n ? 8'h00 : 8'hFF);
            end
        end

        // R11: toggle select with live equal to stored
        en_ab = 1'b1; en_ba_n = 1'b0;
        a_in = exp_sa; b_in = exp_sb;
        for (int t = 0; t < 6; t++) begin
            sel_ab = t[0]; sel_ba = ~t[0];
            #0.2;
            check("R11", b_out, exp_sa);
            check("R11", a_out, exp_sb);
            tick();
            check("R11", b_out, exp_sa);
        end

        // R10: holding loop with bus resolution done here
        sel_ab = 1'b0; sel_ba = 1'b0; en_ab = 1'b1; en_ba_n = 1'b0;
        a_in = 8'h3C; #0.2;
        b_in = b_out; #0.2;
        check("R10", a_out, 8'h3C);
        for (int t = 0; t < 5; t++) begin
            a_in = (a_oe == 8'hFF) ? a_out : a_in; #0.2;
            b_in = (b_oe == 8'hFF) ? b_out : b_in; #0.2;
            tick();
        end
        check("R10", a_in, 8'h3C);
        check("R10", b_in, 8'h3C);
        check("R10", b_out, 8'h3C);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule